// File: doc/BRIEF.md
# Threshold Histogram Valley Search

This block runs once a ramp read has completed and every page-buffer slice holds the threshold code of its cell. It searches for the read level that sits in the valley between two neighbouring threshold distributions. For each candidate code it counts the slices whose stored code equals that candidate. The first candidate is the supplied start level. The following candidates step down by one code each, for a requested number of steps. The candidate with the fewest matching cells becomes the calibrated read level.

A controller places the slice codes on `cell_codes`, sets the start level and the number of lower steps, and pulses `go`. The block walks through the slices one per clock. When the last candidate has been counted, it pulses `done` and presents the winning level with its count. Both values stay unchanged until the next search finishes, so a single search can serve every page of a block. The codes must not change while the search runs.

Top module: `vt_valley_search`

## Requirements
- R1: The count reported for a level equals the number of slices whose stored code equals that level. Slice i occupies bits [i*CODE_W +: CODE_W] of `cell_codes`.
- R2: The first candidate is `start_level`. With `lower_steps` = 0, the result is `start_level` and its count.
- R3: After the start, the candidates are start-1, start-2 and so on, one per step, down to start-`lower_steps`.
- R4: The reported level is the candidate with the smallest count. When counts are equal, the candidate nearest the start, which is the higher code, wins.
- R5: A `lower_steps` value above MAX_STEPS is treated as MAX_STEPS.
- R6: The search never goes below code 0. The number of lower steps is limited to `start_level`.
- R7: Let L be the number of lower steps actually used. `done` goes high exactly (L+1)*SLICES clock edges after the edge that samples `go`.
- R8: `done` is high for a single cycle. `best_level` and `best_count` change only in the cycle where `done` is high and hold their values at all other times.
- R9: A `go` that arrives while a search is running is ignored, and the running search's result is unchanged.
- R10: After reset, `best_level` = 0, `best_count` = 0 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Starts a search when the block is idle |
| start_level | input | CODE_W | First candidate code |
| lower_steps | input | $clog2(MAX_STEPS+1) | Number of candidates below the start |
| cell_codes | input | SLICES*CODE_W | Threshold code of every slice, slice 0 in the low bits |
| best_level | output | CODE_W | Calibrated read level from the last search |
| best_count | output | $clog2(SLICES+1) | Number of cells at `best_level` |
| done | output | 1 | One-cycle pulse when a search finishes |

## Verification
The hardest cases to reach are searches that stop early at code zero, step counts that must be clamped, and ties between candidates. In all of them the chosen level can match the correct answer even when the stepping logic is wrong. The stimulus sweeps every start level and every step count of a 4-bit, 8-slice setup over several code patterns. It checks the exact `done` latency as well as the result, so a walk with the wrong length is exposed even when the winning level happens to agree. Directed patterns with all cells on one code create deliberate ties. A `go` injected in the middle of a search checks that a running search cannot be restarted.

// File: rtl/vtv_pkg.sv
package vtv_pkg;

  // Number of lower steps actually walked: the request is clamped to the
  // configured maximum and to the distance from the start down to code 0.
  function automatic int unsigned vtv_last_step(int unsigned start,
                                                int unsigned steps,
                                                int unsigned max_steps);
    int unsigned s;
    s = (steps > max_steps) ? max_steps : steps;
    return (s > start) ? start : s;
  endfunction

  // Candidate code visited at step k of a search.
  function automatic int unsigned vtv_candidate(int unsigned start,
                                                int unsigned k);
    return start - k;
  endfunction

  // Cycles from the accepting edge to the done edge.
  function automatic int unsigned vtv_latency(int unsigned last_step,
                                              int unsigned slices);
    return (last_step + 1) * slices;
  endfunction

endpackage

// File: rtl/vtv_slice_mux.sv
module vtv_slice_mux #(
  parameter int SLICES = 64,
  parameter int CODE_W = 7,
  parameter int SEL_W  = 6
) (
  input  logic [SLICES*CODE_W-1:0] codes_flat,
  input  logic [SEL_W-1:0]         sel,
  output logic [CODE_W-1:0]        code
);

  logic [CODE_W-1:0] lane [SLICES];

  for (genvar g = 0; g < SLICES; g++) begin : g_lane
    assign lane[g] = codes_flat[g*CODE_W +: CODE_W];
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < SLICES; i++) begin
      if (SEL_W'(i) == sel) code = lane[i];
    end
  end

endmodule

// File: rtl/vtv_scan_ctrl.sv
module vtv_scan_ctrl
  import vtv_pkg::*;
#(
  parameter int SLICES    = 64,
  parameter int CODE_W    = 7,
  parameter int MAX_STEPS = 8,
  parameter int SEL_W     = 6,
  parameter int STEP_W    = 4,
  parameter int CNT_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CODE_W-1:0] start_level,
  input  logic [STEP_W-1:0] lower_steps,
  input  logic              hit,
  output logic              go_accept,
  output logic              busy,
  output logic [SEL_W-1:0]  slice_idx,
  output logic [STEP_W-1:0] k_idx,
  output logic [STEP_W-1:0] last_k,
  output logic [CODE_W-1:0] cand,
  output logic [CODE_W-1:0] start_q,
  output logic [CNT_W-1:0]  cand_total,
  output logic              cand_close,
  output logic              search_end
);

  localparam logic [SEL_W-1:0] LAST_SLICE = SEL_W'(SLICES - 1);

  logic [CNT_W-1:0] acc;

  assign go_accept  = go & ~busy;
  assign cand_total = acc + CNT_W'(hit);
  assign cand_close = busy & (slice_idx == LAST_SLICE);
  assign search_end = cand_close & (k_idx == last_k);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      slice_idx <= '0;
      k_idx     <= '0;
      last_k    <= '0;
      cand      <= '0;
      start_q   <= '0;
      acc       <= '0;
    end else if (go_accept) begin
      busy      <= 1'b1;
      slice_idx <= '0;
      k_idx     <= '0;
      last_k    <= STEP_W'(vtv_last_step(int'(start_level),
                                         int'(lower_steps), MAX_STEPS));
      cand      <= start_level;
      start_q   <= start_level;
      acc       <= '0;
    end else if (busy) begin
      if (cand_close) begin
        acc       <= '0;
        slice_idx <= '0;
        if (search_end) begin
          busy <= 1'b0;
        end else begin
          k_idx <= k_idx + STEP_W'(1);
          cand  <= CODE_W'(vtv_candidate(int'(start_q), int'(k_idx) + 1));
        end
      end else begin
        slice_idx <= slice_idx + SEL_W'(1);
        acc       <= cand_total;
      end
    end
  end

endmodule

// File: rtl/vtv_min_tracker.sv
module vtv_min_tracker #(
  parameter int CODE_W = 7,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close,
  input  logic              first,
  input  logic [CODE_W-1:0] level,
  input  logic [CNT_W-1:0]  total,
  output logic              upd,
  output logic [CODE_W-1:0] nxt_level,
  output logic [CNT_W-1:0]  nxt_count
);

  logic [CODE_W-1:0] run_level;
  logic [CNT_W-1:0]  run_count;

  // Strict less-than keeps the earlier, higher candidate on a tie.
  assign upd       = close & (first | (total < run_count));
  assign nxt_level = upd ? level : run_level;
  assign nxt_count = upd ? total : run_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_level <= '0;
      run_count <= '0;
    end else if (close) begin
      run_level <= nxt_level;
      run_count <= nxt_count;
    end
  end

endmodule

// File: rtl/vt_valley_search.sv
module vt_valley_search #(
  parameter int SLICES    = 64,
  parameter int CODE_W    = 7,
  parameter int MAX_STEPS = 8,
  localparam int SEL_W    = (SLICES > 1) ? $clog2(SLICES) : 1,
  localparam int STEP_W   = $clog2(MAX_STEPS + 1),
  localparam int CNT_W    = $clog2(SLICES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic [CODE_W-1:0]        start_level,
  input  logic [STEP_W-1:0]        lower_steps,
  input  logic [SLICES*CODE_W-1:0] cell_codes,
  output logic [CODE_W-1:0]        best_level,
  output logic [CNT_W-1:0]         best_count,
  output logic                     done
);

  logic              go_accept;
  logic              busy;
  logic [SEL_W-1:0]  slice_idx;
  logic [STEP_W-1:0] k_idx;
  logic [STEP_W-1:0] last_k;
  logic [CODE_W-1:0] cand;
  logic [CODE_W-1:0] start_q;
  logic [CNT_W-1:0]  cand_total;
  logic              cand_close;
  logic              search_end;
  logic [CODE_W-1:0] cur_code;
  logic              hit;
  logic              best_upd;
  logic [CODE_W-1:0] nxt_level;
  logic [CNT_W-1:0]  nxt_count;

  vtv_slice_mux #(
    .SLICES(SLICES), .CODE_W(CODE_W), .SEL_W(SEL_W)
  ) mux_i (
    .codes_flat(cell_codes),
    .sel       (slice_idx),
    .code      (cur_code)
  );

  assign hit = (cur_code == cand);

  vtv_scan_ctrl #(
    .SLICES(SLICES), .CODE_W(CODE_W), .MAX_STEPS(MAX_STEPS),
    .SEL_W(SEL_W), .STEP_W(STEP_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .start_level(start_level),
    .lower_steps(lower_steps),
    .hit        (hit),
    .go_accept  (go_accept),
    .busy       (busy),
    .slice_idx  (slice_idx),
    .k_idx      (k_idx),
    .last_k     (last_k),
    .cand       (cand),
    .start_q    (start_q),
    .cand_total (cand_total),
    .cand_close (cand_close),
    .search_end (search_end)
  );

  vtv_min_tracker #(
    .CODE_W(CODE_W), .CNT_W(CNT_W)
  ) trk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .close    (cand_close),
    .first    (k_idx == '0),
    .level    (cand),
    .total    (cand_total),
    .upd      (best_upd),
    .nxt_level(nxt_level),
    .nxt_count(nxt_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_level <= '0;
      best_count <= '0;
      done       <= 1'b0;
    end else begin
      done <= search_end;
      if (search_end) begin
        best_level <= nxt_level;
        best_count <= nxt_count;
      end
    end
  end

endmodule

// File: rtl/vtv_valley_chk.sv
module vtv_valley_chk #(
  parameter int SLICES = 64,
  parameter int CODE_W = 7,
  parameter int STEP_W = 4,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic              busy,
  input logic              done,
  input logic              search_end,
  input logic [STEP_W-1:0] k_idx,
  input logic [STEP_W-1:0] last_k,
  input logic [CODE_W-1:0] start_q,
  input logic [CODE_W-1:0] best_level,
  input logic [CNT_W-1:0]  best_count
);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(best_level) && $stable(best_count)));

  a_r7_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    search_end |=> (done && !busy));

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go) |=> (start_q == $past(start_q)));

  a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(best_level) <= int'(start_q) &&
              int'(best_level) + int'(last_k) >= int'(start_q)));

  a_r1_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(best_count) <= SLICES);

  a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (k_idx <= last_k));

endmodule

bind vt_valley_search vtv_valley_chk #(
  .SLICES(SLICES), .CODE_W(CODE_W), .STEP_W(STEP_W), .CNT_W(CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .go        (go),
  .busy      (busy),
  .done      (done),
  .search_end(search_end),
  .k_idx     (k_idx),
  .last_k    (last_k),
  .start_q   (start_q),
  .best_level(best_level),
  .best_count(best_count)
);

// File: tb/vt_valley_search_tb_top.sv
module vt_valley_search_tb_top;

  localparam int S    = 8;
  localparam int CW   = 4;
  localparam int MS   = 8;
  localparam int SW   = $clog2(MS + 1);
  localparam int CNTW = $clog2(S + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            go = 1'b0;
  logic [CW-1:0]   start_level = '0;
  logic [SW-1:0]   lower_steps = '0;
  logic [S*CW-1:0] cell_codes = '0;
  logic [CW-1:0]   best_level;
  logic [CNTW-1:0] best_count;
  logic            done;

  int checks = 0;
  int errors = 0;
  int codes [S];

  always #5 clk = ~clk;

  vt_valley_search #(.SLICES(S), .CODE_W(CW), .MAX_STEPS(MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .start_level(start_level),
    .lower_steps(lower_steps), .cell_codes(cell_codes),
    .best_level(best_level), .best_count(best_count), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pack_codes();
    for (int i = 0; i < S; i++) cell_codes[i*CW +: CW] = CW'(codes[i]);
  endtask

  function automatic int hist(int v);
    int n = 0;
    for (int i = 0; i < S; i++) if (codes[i] == v) n++;
    return n;
  endfunction

  // Runs one search; inj >= 0 pulses a second go (start 3) after inj cycles.
  task automatic run(input int st, input int sp, input int inj, input string tag);
    int lim, last, cyc, e_lvl, e_cnt, c;
    pack_codes();
    @(negedge clk);
    start_level = CW'(st);
    lower_steps = SW'(sp);
    go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    go = 1'b0;
    cyc = 0;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (cyc == inj) begin
        go = 1'b1;
        start_level = CW'(3);
      end else begin
        go = 1'b0;
      end
    end while (!done && cyc < 2000);
    go = 1'b0;
    lim  = (sp > MS) ? MS : sp;
    last = (lim > st) ? st : lim;
    e_lvl = st;
    e_cnt = hist(st);
    for (int k = 1; k <= last; k++) begin
      c = hist(st - k);
      if (c < e_cnt) begin
        e_cnt = c;
        e_lvl = st - k;
      end
    end
    check(cyc == (last + 1) * S, {tag, " R7 latency"}, cyc, (last + 1) * S);
    check(int'(best_level) == e_lvl, {tag, " R3 R4 R6 level"}, int'(best_level), e_lvl);
    check(int'(best_count) == e_cnt, {tag, " R1 count"}, int'(best_count), e_cnt);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, {tag, " R8 done one cycle"}, int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int keep_lvl, keep_cnt;
    for (int i = 0; i < S; i++) codes[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(best_level == '0, "R10 reset level", int'(best_level), 0);
    check(best_count == '0, "R10 reset count", int'(best_count), 0);
    check(done == 1'b0, "R10 reset done", int'(done), 0);
    rst_n = 1'b1;

    // R2: every cell on code 9, no lower steps
    for (int i = 0; i < S; i++) codes[i] = 9;
    run(9, 0, -1, "R2 start only");
    check(int'(best_level) == 9 && int'(best_count) == S, "R2 start result",
          int'(best_level), 9);
    // R4: lower candidates all zero, tie resolved to the highest of them
    run(9, 3, -1, "R4 tie");
    check(int'(best_level) == 8, "R4 tie nearest start", int'(best_level), 8);

    // R5: request above the maximum is clamped (latency 9 candidates)
    for (int i = 0; i < S; i++) codes[i] = 12 - i;
    run(12, 15, -1, "R5 clamp");

    // R6: early stop at code 0
    for (int i = 0; i < S; i++) codes[i] = 0;
    run(2, 8, -1, "R6 floor");
    check(int'(best_level) == 2 && int'(best_count) == 0, "R6 floor result",
          int'(best_level), 2);

    // R9: go during a running search is ignored
    for (int i = 0; i < S; i++) codes[i] = (i * 5 + 3) % 16;
    run(10, 8, 5, "R9 busy go");

    // R8: outputs hold while codes change and no go arrives
    keep_lvl = int'(best_level);
    keep_cnt = int'(best_count);
    @(negedge clk);
    cell_codes = '1;
    repeat (20) @(negedge clk);
    check(int'(best_level) == keep_lvl, "R8 hold level", int'(best_level), keep_lvl);
    check(int'(best_count) == keep_cnt, "R8 hold count", int'(best_count), keep_cnt);
    check(done == 1'b0, "R8 no spurious done", int'(done), 0);

    // Sweeps: every start and step count over several code patterns
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < S; i++) begin
        case (p)
          0: codes[i] = $urandom_range(0, 15);
          1: codes[i] = (i < 4) ? 3 + (i % 2) : 11 + (i % 3);
          2: codes[i] = i % 3;
          default: codes[i] = $urandom_range(6, 9);
        endcase
      end
      for (int st = 0; st < 16; st++) begin
        for (int sp = 0; sp < 16; sp++) begin
          run(st, sp, -1, "sweep R1 R3 R5 R6");
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule